// File: doc/BRIEF.md
# SCSI Host Adapter Register Front End

This block is the byte-wide register face of a simple SCSI initiator controller. A host reaches sixteen register slots through a memory-mapped bus. The slot number comes from the bus address shifted right by a parameter. Reads and writes at the same slot usually reach different storage. The block keeps a readable bank (status, interrupt cause, sequence step, FIFO flags, live transfer count, command echo, configuration mirrors and a chip identifier) and a write-only bank (target id, written transfer count, timing and test slots). It decodes command bytes and drives a single level interrupt line.

Data movement is left to neighbouring blocks. The data FIFO sees push and pop strobes. The transfer and bus engines see a one-cycle command strobe that carries the opcode and the DMA qualifier, and they report back through a completion-report strobe and two error pulses. A small command state machine has two states. `FS_IDLE` waits for a command byte. `FS_EXEC` lasts one cycle, announces the command and applies its local effects. A command write moves `FS_IDLE` to `FS_EXEC`. `FS_EXEC` stays in `FS_EXEC` if another command byte arrives, and otherwise returns to `FS_IDLE`. A chip-reset command forces `FS_IDLE`.

Top module: `sha_regfront`

## Requirements
- R1: After the external reset, every readable slot reads 0x00 except slot 8 (configuration 1), which reads 0x07, and slot 0xE, which reads the chip identifier 0x04. The irq output is low, and the target id and written transfer length outputs are zero.
- R2: The register slot is the bus address shifted right by ADDR_SHIFT (default 2), so the address bits below the shift do not affect which slot is reached.
- R3: Writes to slots 8 and 0xB to 0xF are visible when those slots are read back. Writes to slots 4 to 7, 9 and 0xA land only in the write-only bank and leave the read value of the slot unchanged. Slot 4 bits 2:0 drive the target id output.
- R4: A write to slot 3 is echoed when slot 3 is read in the next cycle. On the following cycle, cmd_valid is high for exactly one cycle, with cmd_op equal to bits 6:0 of the byte and cmd_dma equal to bit 7.
- R5: Writes to slots 0 (count low) and 1 (count mid) appear on the written-length output but do not change the readable count. A command byte with bit 7 set copies the written count low and mid bytes into the readable count slots.
- R6: A write to slot 0 or slot 1 clears status bit 4 (terminal count).
- R7: Reading slot 5 (interrupt cause) clears status bits 7, 6 (gross error) and 5 (parity error) and lowers irq. The interrupt cause value itself is returned unchanged.
- R8: The irq output always equals status bit 7. A completion report sets that bit and irq, and a second raise while the bit is already set leaves both set.
- R9: Opcode 0x01 (flush) loads 0x08 into the interrupt cause, zeroes the sequence step (slot 6) and the FIFO flags (slot 7), and does not raise irq.
- R10: Opcode 0x03 (bus reset) loads 0x80 into the interrupt cause. It raises irq only when bit 6 of the last value written to configuration 1 is clear.
- R11: Opcode 0x02 (chip reset) restores every readable and write-only slot and irq to the R1 state.
- R12: Opcode 0x44 (enable selection) zeroes the interrupt cause. Opcodes 0x00 and 0x1A and any undefined opcode change nothing except the slot-3 echo, and do not raise irq.
- R13: A write to slot 2 pulses fifo_push for that cycle with fifo_wdata equal to the byte. A read of slot 2 pulses fifo_pop and returns fifo_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effects on the clock edge) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed slot |
| irq | output | 1 | Level interrupt request |
| cmd_valid | output | 1 | One-cycle command announcement |
| cmd_op | output | 7 | Opcode of the announced command |
| cmd_dma | output | 1 | DMA qualifier of the announced command |
| tgt_id | output | 3 | Target id from write-only slot 4 |
| xfer_len | output | 16 | Written transfer count {mid, low} |
| fifo_push | output | 1 | FIFO write strobe |
| fifo_wdata | output | 8 | FIFO write data |
| fifo_pop | output | 1 | FIFO read strobe |
| fifo_rdata | input | 8 | FIFO head byte |
| rpt_valid | input | 1 | Completion report strobe, raises the interrupt |
| rpt_stat | input | 5 | New status bits 4:0 |
| rpt_intr | input | 8 | New interrupt cause |
| rpt_seq | input | 3 | New sequence step |
| rpt_flags | input | 8 | New FIFO flags |
| ev_gross | input | 1 | Sets status bit 6 |
| ev_parity | input | 1 | Sets status bit 5 |

## Verification
The bench targets the read/write split at shared slots. If the write-only slots were mirrored, the status and interrupt-cause reads would return the written bytes. It checks that a written count reaches the readable count only through a DMA-qualified command, since a design that copied it on the count write itself would show the count early. It reads the interrupt cause and expects only status bits 7:5 and irq to clear. A design that also cleared terminal count or the cause byte, or that left irq high, would show the wrong bytes. It runs bus reset with configuration bit 6 set and clear, and runs chip reset after dirtying both banks. A wrong polarity or a missed clear leaves irq, the target id or the written length off.

// File: rtl/sha_pkg.sv
package sha_pkg;
    localparam int NREG  = 16;
    localparam int IDX_W = 4;

    typedef logic [7:0] byte_t;

    localparam logic [IDX_W-1:0] IX_CNT_LO = 4'h0;
    localparam logic [IDX_W-1:0] IX_CNT_MD = 4'h1;
    localparam logic [IDX_W-1:0] IX_FIFO   = 4'h2;
    localparam logic [IDX_W-1:0] IX_CMD    = 4'h3;
    localparam logic [IDX_W-1:0] IX_STAT   = 4'h4;
    localparam logic [IDX_W-1:0] IX_INTR   = 4'h5;
    localparam logic [IDX_W-1:0] IX_SEQ    = 4'h6;
    localparam logic [IDX_W-1:0] IX_FLAGS  = 4'h7;
    localparam logic [IDX_W-1:0] IX_CFG1   = 4'h8;
    localparam logic [IDX_W-1:0] IX_CHIPID = 4'hE;

    // slots whose written value becomes the readable value
    localparam logic [NREG-1:0] MIRROR_MASK = 16'hF900;

    localparam int ST_IRQ = 7;
    localparam int ST_GE  = 6;
    localparam int ST_PE  = 5;
    localparam int ST_TC  = 4;
    localparam int CFG1_NO_RST_IRQ = 6;

    localparam byte_t CHIP_ID     = 8'h04;
    localparam byte_t CFG1_DEF    = 8'h07;
    localparam byte_t CAUSE_DONE  = 8'h08;
    localparam byte_t CAUSE_BUSRS = 8'h80;

    localparam logic [6:0] OP_NOP    = 7'h00;
    localparam logic [6:0] OP_FLUSH  = 7'h01;
    localparam logic [6:0] OP_CHRST  = 7'h02;
    localparam logic [6:0] OP_BUSRST = 7'h03;
    localparam logic [6:0] OP_ATN    = 7'h1A;
    localparam logic [6:0] OP_ENSEL  = 7'h44;

    typedef enum logic {FS_IDLE, FS_EXEC} fsm_t;

    typedef enum logic [2:0] {
        OK_NONE, OK_FLUSH, OK_CHRST, OK_BUSRST, OK_ENSEL
    } opkind_t;
endpackage

// File: rtl/sha_addr_decode.sv
module sha_addr_decode
    import sha_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int ADDR_SHIFT = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output logic [IDX_W-1:0]  idx,
    output logic [NREG-1:0]   wr_hit
);
    logic [ADDR_W-1:0] shifted;

    assign shifted = addr >> ADDR_SHIFT;
    assign idx     = shifted[IDX_W-1:0];

    for (genvar g = 0; g < NREG; g++) begin : g_hit
        assign wr_hit[g] = wr && (idx == IDX_W'(g));
    end
endmodule

// File: rtl/sha_cmd_decode.sv
module sha_cmd_decode
    import sha_pkg::*;
(
    input  logic [6:0] op,
    output opkind_t    kind
);
    always_comb begin
        unique case (op)
            OP_FLUSH:  kind = OK_FLUSH;
            OP_CHRST:  kind = OK_CHRST;
            OP_BUSRST: kind = OK_BUSRST;
            OP_ENSEL:  kind = OK_ENSEL;
            default:   kind = OK_NONE;
        endcase
    end
endmodule

// File: rtl/sha_cmd_fsm.sv
module sha_cmd_fsm
    import sha_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       soft_rst,
    input  logic       cmd_wr,
    input  byte_t      cmd_byte,
    output logic       cmd_valid,
    output logic [6:0] cmd_op,
    output logic       cmd_dma
);
    fsm_t       state_q, state_d;
    logic [6:0] op_q;
    logic       dma_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (soft_rst) begin
            state_d = FS_IDLE;
        end else begin
            unique case (state_q)
                FS_IDLE: if (cmd_wr) state_d = FS_EXEC;
                FS_EXEC: state_d = cmd_wr ? FS_EXEC : FS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q  <= OP_NOP;
            dma_q <= 1'b0;
        end else if (cmd_wr) begin
            op_q  <= cmd_byte[6:0];
            dma_q <= cmd_byte[7];
        end
    end

    always_comb begin
        cmd_valid = (state_q == FS_EXEC);
        cmd_op    = op_q;
        cmd_dma   = dma_q;
    end
endmodule

// File: rtl/sha_regfront.sv
module sha_regfront
    import sha_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int ADDR_SHIFT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq,
    output logic              cmd_valid,
    output logic [6:0]        cmd_op,
    output logic              cmd_dma,
    output logic [2:0]        tgt_id,
    output logic [15:0]       xfer_len,
    output logic              fifo_push,
    output logic [7:0]        fifo_wdata,
    output logic              fifo_pop,
    input  logic [7:0]        fifo_rdata,
    input  logic              rpt_valid,
    input  logic [4:0]        rpt_stat,
    input  logic [7:0]        rpt_intr,
    input  logic [2:0]        rpt_seq,
    input  logic [7:0]        rpt_flags,
    input  logic              ev_gross,
    input  logic              ev_parity
);
    logic [IDX_W-1:0] idx;
    logic [NREG-1:0]  wr_hit;
    opkind_t          kind;
    logic             chip_rst;
    logic             irq_q;
    byte_t            rreg [NREG];
    byte_t            wreg [NREG];

    sha_addr_decode #(.ADDR_W(ADDR_W), .ADDR_SHIFT(ADDR_SHIFT)) u_adec (
        .addr   (bus_addr),
        .wr     (bus_wr),
        .idx    (idx),
        .wr_hit (wr_hit)
    );

    sha_cmd_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (chip_rst),
        .cmd_wr    (wr_hit[IX_CMD]),
        .cmd_byte  (bus_wdata),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_dma   (cmd_dma)
    );

    sha_cmd_decode u_cdec (
        .op   (cmd_op),
        .kind (kind)
    );

    assign chip_rst = cmd_valid && (kind == OK_CHRST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                rreg[i] <= '0;
                wreg[i] <= '0;
            end
            rreg[IX_CHIPID] <= CHIP_ID;
            rreg[IX_CFG1]   <= CFG1_DEF;
            irq_q           <= 1'b0;
        end else if (chip_rst) begin
            for (int i = 0; i < NREG; i++) begin
                rreg[i] <= '0;
                wreg[i] <= '0;
            end
            rreg[IX_CHIPID] <= CHIP_ID;
            rreg[IX_CFG1]   <= CFG1_DEF;
            irq_q           <= 1'b0;
        end else begin
            // host writes: every slot keeps a written copy, some mirror
            for (int i = 0; i < NREG; i++) begin
                if (wr_hit[i]) begin
                    wreg[i] <= bus_wdata;
                    if (MIRROR_MASK[i]) rreg[i] <= bus_wdata;
                end
            end
            if (wr_hit[IX_CMD]) begin
                rreg[IX_CMD] <= bus_wdata;
                if (bus_wdata[7]) begin
                    rreg[IX_CNT_LO] <= wreg[IX_CNT_LO];
                    rreg[IX_CNT_MD] <= wreg[IX_CNT_MD];
                end
            end
            if (wr_hit[IX_CNT_LO] || wr_hit[IX_CNT_MD])
                rreg[IX_STAT][ST_TC] <= 1'b0;

            // host read of the interrupt cause acknowledges
            if (bus_rd && (idx == IX_INTR)) begin
                rreg[IX_STAT][ST_IRQ] <= 1'b0;
                rreg[IX_STAT][ST_GE]  <= 1'b0;
                rreg[IX_STAT][ST_PE]  <= 1'b0;
                irq_q                 <= 1'b0;
            end

            // neighbour events
            if (ev_gross)  rreg[IX_STAT][ST_GE] <= 1'b1;
            if (ev_parity) rreg[IX_STAT][ST_PE] <= 1'b1;
            if (rpt_valid) begin
                rreg[IX_STAT][4:0]    <= rpt_stat;
                rreg[IX_INTR]         <= rpt_intr;
                rreg[IX_SEQ]          <= {5'd0, rpt_seq};
                rreg[IX_FLAGS]        <= rpt_flags;
                rreg[IX_STAT][ST_IRQ] <= 1'b1;
                irq_q                 <= 1'b1;
            end

            // local effects of the announced command
            if (cmd_valid) begin
                unique case (kind)
                    OK_FLUSH: begin
                        rreg[IX_INTR]  <= CAUSE_DONE;
                        rreg[IX_SEQ]   <= '0;
                        rreg[IX_FLAGS] <= '0;
                    end
                    OK_BUSRST: begin
                        rreg[IX_INTR] <= CAUSE_BUSRS;
                        if (!wreg[IX_CFG1][CFG1_NO_RST_IRQ]) begin
                            rreg[IX_STAT][ST_IRQ] <= 1'b1;
                            irq_q                 <= 1'b1;
                        end
                    end
                    OK_ENSEL: rreg[IX_INTR] <= '0;
                    default: ;
                endcase
            end
        end
    end

    assign bus_rdata  = (idx == IX_FIFO) ? fifo_rdata : rreg[idx];
    assign irq        = irq_q;
    assign tgt_id     = wreg[IX_STAT][2:0];
    assign xfer_len   = {wreg[IX_CNT_MD], wreg[IX_CNT_LO]};
    assign fifo_push  = wr_hit[IX_FIFO];
    assign fifo_wdata = bus_wdata;
    assign fifo_pop   = bus_rd && (idx == IX_FIFO);
endmodule

// File: rtl/sha_regfront_chk.sv
module sha_regfront_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [3:0] idx,
    input logic [7:0] bus_wdata,
    input logic       irq,
    input logic       cmd_valid,
    input logic [6:0] cmd_op,
    input logic [7:0] stat,
    input logic [7:0] cause,
    input logic [7:0] cnt_lo,
    input logic [7:0] cnt_lo_w,
    input logic [7:0] chipid,
    input logic       cfg1_w6,
    input logic       rpt_valid,
    input logic       ev_gross,
    input logic       ev_parity
);
    logic reset_cmd;
    assign reset_cmd = cmd_valid && (cmd_op == 7'h02);

    AST_IRQ_IS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq == stat[7]); // R8

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && idx == 4'h5 && !rpt_valid && !cmd_valid && !ev_gross && !ev_parity)
        |=> (!irq && stat[7:5] == 3'b000)); // R7

    AST_TC_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && idx < 4'h2 && !rpt_valid) |=> !stat[4]); // R6

    AST_DMA_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && idx == 4'h3 && bus_wdata[7] && !cmd_valid)
        |=> cnt_lo == $past(cnt_lo_w)); // R5

    AST_CMD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && idx == 4'h3 && !reset_cmd)
        |=> (cmd_valid && cmd_op == $past(bus_wdata[6:0]))); // R4

    AST_BUSRST_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 7'h03 && !cfg1_w6) |=> irq); // R10

    AST_CHIPRST_ID: assert property (@(posedge clk) disable iff (!rst_n)
        reset_cmd |=> (chipid == 8'h04 && !irq)); // R11

    AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 7'h01 && !rpt_valid) |=> cause == 8'h08); // R9
endmodule

bind sha_regfront sha_regfront_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .idx       (idx),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .stat      (rreg[4]),
    .cause     (rreg[5]),
    .cnt_lo    (rreg[0]),
    .cnt_lo_w  (wreg[0]),
    .chipid    (rreg[14]),
    .cfg1_w6   (wreg[8][6]),
    .rpt_valid (rpt_valid),
    .ev_gross  (ev_gross),
    .ev_parity (ev_parity)
);

// File: tb/tb_sha_regfront.sv
module tb_sha_regfront;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        irq, cmd_valid, cmd_dma, fifo_push, fifo_pop;
    logic [6:0]  cmd_op;
    logic [2:0]  tgt_id;
    logic [15:0] xfer_len;
    logic [7:0]  fifo_wdata;
    logic [7:0]  fifo_rdata = 8'h5A;
    logic        rpt_valid = 1'b0;
    logic [4:0]  rpt_stat = '0;
    logic [7:0]  rpt_intr = '0, rpt_flags = '0;
    logic [2:0]  rpt_seq = '0;
    logic        ev_gross = 1'b0, ev_parity = 1'b0;

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    sha_regfront dut (.*);

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] slot, input logic [7:0] d);
        @(negedge clk);
        bus_addr = {2'b00, slot, 2'b00};
        bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] slot, output logic [7:0] d);
        @(negedge clk);
        bus_addr = {2'b00, slot, 2'b00}; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] slot, input logic [7:0] exp);
        logic [7:0] v;
        rd(slot, v);
        check(req, v, exp);
    endtask

    task automatic cmd(input logic [7:0] b);
        wr(4'h3, b);
        @(negedge clk);
    endtask

    task automatic report(input logic [4:0] s, input logic [7:0] c,
                          input logic [2:0] q, input logic [7:0] f);
        @(negedge clk);
        rpt_stat = s; rpt_intr = c; rpt_seq = q; rpt_flags = f; rpt_valid = 1'b1;
        @(negedge clk);
        rpt_valid = 1'b0;
    endtask

    task automatic ack();
        logic [7:0] v;
        rd(4'h5, v);
    endtask

    task automatic check_defaults(input string req);
        for (int i = 0; i < 16; i++) begin
            if (i == 2) continue;
            rd_chk(req, 4'(i), (i == 8) ? 8'h07 : (i == 14) ? 8'h04 : 8'h00);
        end
        check(req, irq, 0);
        check(req, tgt_id, 0);
        check(req, xfer_len, 0);
    endtask

    task automatic t_reset();
        check_defaults("R1");
    endtask

    task automatic t_addr();
        logic [7:0] v;
        @(negedge clk);
        bus_addr = {2'b00, 4'h8, 2'b11}; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
        check("R2", v, 8'h07);
        @(negedge clk);
        bus_addr = {2'b00, 4'hB, 2'b01}; bus_wdata = 8'h3C; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        rd_chk("R2", 4'hB, 8'h3C);
    endtask

    task automatic t_split();
        wr(4'h4, 8'h05);
        check("R3", tgt_id, 3'd5);
        rd_chk("R3", 4'h4, 8'h00);
        wr(4'h5, 8'hFF);
        rd_chk("R3", 4'h5, 8'h00);
        check("R3", irq, 0);
        wr(4'h9, 8'h11);
        rd_chk("R3", 4'h9, 8'h00);
        wr(4'hC, 8'hA5);
        rd_chk("R3", 4'hC, 8'hA5);
        wr(4'h8, 8'h17);
        rd_chk("R3", 4'h8, 8'h17);
        wr(4'h8, 8'h07);
    endtask

    task automatic t_cmd_dma();
        wr(4'h0, 8'h34);
        wr(4'h1, 8'h12);
        check("R5", xfer_len, 16'h1234);
        rd_chk("R5", 4'h0, 8'h00);
        wr(4'h3, 8'h00);
        check("R4", cmd_valid, 1);
        check("R4", cmd_op, 7'h00);
        check("R4", cmd_dma, 0);
        @(negedge clk);
        check("R4", cmd_valid, 0);
        rd_chk("R5", 4'h0, 8'h00);
        wr(4'h3, 8'h90);
        check("R4", cmd_valid, 1);
        check("R4", cmd_op, 7'h10);
        check("R4", cmd_dma, 1);
        @(negedge clk);
        rd_chk("R5", 4'h0, 8'h34);
        rd_chk("R5", 4'h1, 8'h12);
        rd_chk("R4", 4'h3, 8'h90);
        check("R12", irq, 0);
    endtask

    task automatic t_tc_ack();
        report(5'h11, 8'h18, 3'd4, 8'h02);
        check("R8", irq, 1);
        rd_chk("R8", 4'h4, 8'h91);
        rd_chk("R7", 4'h5, 8'h18);
        check("R7", irq, 0);
        rd_chk("R7", 4'h4, 8'h11);
        rd_chk("R7", 4'h5, 8'h18);
        wr(4'h0, 8'h00);
        rd_chk("R6", 4'h4, 8'h01);
    endtask

    task automatic t_errors();
        @(negedge clk);
        ev_gross = 1'b1; ev_parity = 1'b1;
        @(negedge clk);
        ev_gross = 1'b0; ev_parity = 1'b0;
        rd_chk("R7", 4'h4, 8'h61);
        check("R8", irq, 0);
        report(5'h03, 8'h10, 3'd1, 8'h00);
        rd_chk("R7", 4'h4, 8'hE3);
        ack();
        rd_chk("R7", 4'h4, 8'h03);
        check("R7", irq, 0);
    endtask

    task automatic t_double_raise();
        report(5'h02, 8'h18, 3'd4, 8'h02);
        report(5'h02, 8'h18, 3'd4, 8'h02);
        check("R8", irq, 1);
        rd_chk("R8", 4'h4, 8'h82);
        ack();
        check("R8", irq, 0);
    endtask

    task automatic t_flush();
        rd_chk("R9", 4'h6, 8'h04);
        rd_chk("R9", 4'h7, 8'h02);
        cmd(8'h01);
        rd_chk("R9", 4'h5, 8'h08);
        rd_chk("R9", 4'h6, 8'h00);
        rd_chk("R9", 4'h7, 8'h00);
        check("R9", irq, 0);
    endtask

    task automatic t_busrst();
        wr(4'h8, 8'h47);
        cmd(8'h03);
        rd_chk("R10", 4'h5, 8'h80);
        check("R10", irq, 0);
        wr(4'h8, 8'h07);
        cmd(8'h03);
        check("R10", irq, 1);
        rd_chk("R10", 4'h4, 8'h82);
        ack();
    endtask

    task automatic t_quiet_ops();
        cmd(8'h44);
        rd_chk("R12", 4'h5, 8'h00);
        report(5'h00, 8'h18, 3'd3, 8'h05);
        ack();
        cmd(8'h1A);
        cmd(8'h7F);
        cmd(8'h00);
        rd_chk("R12", 4'h5, 8'h18);
        rd_chk("R12", 4'h6, 8'h03);
        rd_chk("R12", 4'h7, 8'h05);
        rd_chk("R12", 4'h3, 8'h00);
        check("R12", irq, 0);
    endtask

    task automatic t_fifo();
        @(negedge clk);
        bus_addr = {2'b00, 4'h2, 2'b00}; bus_wdata = 8'hC3; bus_wr = 1'b1;
        #1 check("R13", fifo_push, 1);
        check("R13", fifo_wdata, 8'hC3);
        @(negedge clk);
        bus_wr = 1'b0;
        #1 check("R13", fifo_push, 0);
        @(negedge clk);
        bus_rd = 1'b1;
        #1 check("R13", fifo_pop, 1);
        check("R13", bus_rdata, 8'h5A);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic t_chip_reset();
        wr(4'h8, 8'h47);
        wr(4'hC, 8'hA5);
        wr(4'h4, 8'h06);
        wr(4'h1, 8'h77);
        report(5'h13, 8'h18, 3'd2, 8'h01);
        check("R11", irq, 1);
        cmd(8'h02);
        check_defaults("R11");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_addr();
        t_split();
        t_cmd_dma();
        t_tc_ack();
        t_errors();
        t_double_raise();
        t_flush();
        t_busrst();
        t_quiet_ops();
        t_fifo();
        t_chip_reset();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule